// File: doc/BRIEF.md
# Overlapping Three-Bit Dual-Pattern Detector

This block watches a serial stream that delivers one bit per cycle in which a valid strobe is high. After each accepted bit it looks at the window made of that bit and the two accepted before it. It raises a one-bit match flag when the window, oldest bit first, reads 0,1,1 or 1,1,0. Matches may overlap, so a single bit can close one match and then take part in the next. For example, the stream 0,1,1,0 yields the flags 0,0,1,1.

The recogniser is an explicit state machine in which each state records how much history is known. There are seven states:
- `ST_EMPTY`: no bits have been accepted.
- `ST_SAW0` and `ST_SAW1`: one bit has been accepted, and the state names its value.
- `ST_P00`, `ST_P01`, `ST_P10` and `ST_P11`: two or more bits have been accepted, and the state holds the last two, older bit first.

The transitions are as follows:
- From `ST_EMPTY`, an accepted bit b leads to `ST_SAWb`.
- From `ST_SAWa`, an accepted bit b leads to `ST_Pab`.
- From `ST_Pxy`, an accepted bit b leads to `ST_Pyb`.
- A cycle with the strobe low leaves the state unchanged.
- Synchronous reset returns the machine to `ST_EMPTY` from any state.

The match flag is registered. It is loaded on every accepted bit from the current state and the incoming bit: `ST_P01` with a 1, or `ST_P11` with a 0. It keeps its value while the strobe is low.

Top module: `dual_pattern_detector`

## Requirements
- R1: While synchronous reset is high at a clock edge, the match flag is 0 after that edge and all history is discarded.
- R2: After an accepted bit completes the window 0,1,1 (oldest first), the match flag is 1 from the next clock edge.
- R3: After an accepted bit completes the window 1,1,0 (oldest first), the match flag is 1 from the next clock edge.
- R4: Matches overlap: the stream 0,1,1,0 gives flags 0,0,1,1. On any stream, each accepted bit sets the flag to the match result of the window that ends at that bit.
- R5: The flag stays 0 for the first two bits accepted after reset, whatever their values.
- R6: In a cycle where the strobe is low, the data input is ignored and both the flag and the history hold. A pattern spread across idle gaps is still detected.
- R7: The six other windows (000, 001, 010, 100, 101, 111) set the flag to 0.
- R8: History from before a reset never contributes to a window after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when bit_in carries a stream bit this cycle |
| bit_in | input | 1 | Serial data bit |
| match | output | 1 | Registered flag: window ending at the last accepted bit is 011 or 110 |

## Verification
The stream 0,1,1,0 right after reset separates a correct fill phase (no flag for the first two bits) and overlap (two flags in a row from different patterns) from a design that waits for non-overlapping windows. A walk that passes through all eight windows shows that only 011 and 110 fire. Bits spread across idle gaps, with junk on the data line, show that the strobe alone gates history updates. A reset placed just after the prefix 0,1 shows that no stale bits complete a 011. A long pseudo-random stream with a random strobe is then compared cycle by cycle with a queue-based model.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    // How much history is known, and its value.
    typedef enum logic [2:0] {
        ST_EMPTY = 3'd0,
        ST_SAW0  = 3'd1,
        ST_SAW1  = 3'd2,
        ST_P00   = 3'd3,
        ST_P01   = 3'd4,
        ST_P10   = 3'd5,
        ST_P11   = 3'd6
    } dpd_state_e;

endpackage

// File: rtl/dpd_next_state.sv
module dpd_next_state
    import dpd_pkg::*;
(
    input  dpd_state_e cur_state,
    input  logic       take,
    input  logic       din,
    output dpd_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;
        if (take) begin
            unique case (cur_state)
                ST_EMPTY: nxt_state = din ? ST_SAW1 : ST_SAW0;
                ST_SAW0:  nxt_state = din ? ST_P01  : ST_P00;
                ST_SAW1:  nxt_state = din ? ST_P11  : ST_P10;
                ST_P00:   nxt_state = din ? ST_P01  : ST_P00;
                ST_P01:   nxt_state = din ? ST_P11  : ST_P10;
                ST_P10:   nxt_state = din ? ST_P01  : ST_P00;
                ST_P11:   nxt_state = din ? ST_P11  : ST_P10;
                default:  nxt_state = ST_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/dpd_match_decode.sv
module dpd_match_decode
    import dpd_pkg::*;
(
    input  dpd_state_e cur_state,
    input  logic       din,
    output logic       hit
);

    // The window ending at din matches 0,1,1 or 1,1,0.
    always_comb begin
        unique case (cur_state)
            ST_P01:  hit = din;
            ST_P11:  hit = ~din;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
    import dpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic match
);

    dpd_state_e state_q;
    dpd_state_e state_d;
    logic       hit;

    dpd_next_state u_next (
        .cur_state (state_q),
        .take      (bit_vld),
        .din       (bit_in),
        .nxt_state (state_d)
    );

    dpd_match_decode u_dec (
        .cur_state (state_q),
        .din       (bit_in),
        .hit       (hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst)          match <= 1'b0;
        else if (bit_vld) match <= hit;
    end

endmodule

// File: rtl/dpd_checker.sv
module dpd_checker (
    input logic clk,
    input logic rst,
    input logic bit_vld,
    input logic bit_in,
    input logic match
);

    // Independent shadow: last two accepted bits and a saturating fill count.
    logic [1:0] last2;
    logic [1:0] seen;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            last2 <= 2'b00;
            seen  <= 2'd0;
        end else if (bit_vld) begin
            last2 <= {last2[0], bit_in};
            if (seen != 2'd2) seen <= seen + 2'd1;
        end
    end

    always_ff @(posedge clk) armed <= 1'b1;

    p_reset_clear_r1: assert property (@(posedge clk)
        armed && $past(rst) |-> !match);

    p_pat011_r2: assert property (@(posedge clk) disable iff (rst)
        bit_vld && seen == 2'd2 && last2 == 2'b01 && bit_in |=> match);

    p_pat110_r3: assert property (@(posedge clk) disable iff (rst)
        bit_vld && seen == 2'd2 && last2 == 2'b11 && !bit_in |=> match);

    p_fill_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        bit_vld && seen != 2'd2 |=> !match);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        armed && !bit_vld |=> $stable(match));

    p_other_windows_r7: assert property (@(posedge clk) disable iff (rst)
        bit_vld && seen == 2'd2
        && !(last2 == 2'b01 && bit_in) && !(last2 == 2'b11 && !bit_in) |=> !match);

endmodule

bind dual_pattern_detector dpd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .match   (match)
);

// File: tb/sim_dual_pattern_detector.sv
module sim_dual_pattern_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic match;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit   done = 1'b0;

    always #2 clk = ~clk;

    dual_pattern_detector u0 (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .match   (match)
    );

    // Behavioural reference: queue of accepted bits.
    bit   hist[$];
    logic exp_m = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            exp_m = 1'b0;
        end else if (bit_vld) begin
            hist.push_back(bit_in);
            if (hist.size() > 3) void'(hist.pop_front());
            exp_m = (hist.size() == 3) &&
                    ((hist[0] == 0 && hist[1] == 1 && hist[2] == 1) ||
                     (hist[0] == 1 && hist[1] == 1 && hist[2] == 0));
        end
    end

    // Per-clock comparison with the model.
    always @(negedge clk) begin
        if (!done && $time > 10) begin
            checks++;
            if (match !== exp_m) begin
                errors++;
                $display("FAIL %s model compare: match=%b expected %b at %0t",
                         phase, match, exp_m, $time);
            end
        end
    end

    task automatic expect_m(input logic e, input string tag);
        checks++;
        if (match !== e) begin
            errors++;
            $display("FAIL %s: match=%b expected %b", tag, match, e);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(posedge clk);
        #1;
        bit_vld = 1'b0;
        bit_in  = ~b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = i[0];
        end
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        expect_m(1'b0, "R1 reset state");

        phase = "R4";
        send(0); expect_m(0, "R5 first bit");
        send(1); expect_m(0, "R5 second bit");
        send(1); expect_m(1, "R2 window 011");
        send(0); expect_m(1, "R4 overlap 110");

        phase = "R7";
        send(1); expect_m(0, "R7 window 101");
        send(0); expect_m(0, "R7 window 010");
        send(0); expect_m(0, "R7 window 100");
        send(0); expect_m(0, "R7 window 000");
        send(1); expect_m(0, "R7 window 001");
        send(1); expect_m(1, "R2 window 011 again");
        send(1); expect_m(0, "R7 window 111");
        send(0); expect_m(1, "R3 window 110");

        phase = "R6";
        idle(4); expect_m(1, "R6 flag held through idle");
        send(1); expect_m(0, "R6 window 101");
        idle(3); expect_m(0, "R6 zero held through idle");
        send(1); expect_m(1, "R6 011 across gaps");
        send(0);
        send(1);
        expect_m(0, "R7 window 101 before reset");

        phase = "R8";
        pulse_reset();
        expect_m(0, "R1 reset mid-stream");
        send(1); expect_m(0, "R8 stale 0,1 not reused");
        send(1); expect_m(0, "R5 two bits after reset");
        send(0); expect_m(1, "R3 110 after reset");

        phase = "R4";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bit_vld = ($urandom_range(0, 3) != 0);
            bit_in  = $urandom_range(0, 1) != 0;
        end
        @(negedge clk);
        bit_vld = 1'b0;
        @(posedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        done = 1'b1;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule